// File: doc/BRIEF.md
# Writeback Buffer with Overflow Queue

This block parks dirty-line writebacks from one CPU until the bus and memory take them. It has a fixed set of slots. Each slot holds a line address and runs a small state machine through five states: IDLE (slot empty), OVHD (the issue overhead delay before the bus), ARB (waiting for bus arbitration), XFER (waiting for the bus transfer) and MEMW (waiting on a busy memory). The transitions are LOAD (IDLE to OVHD, or any state straight to OVHD when a freed slot is refilled in the same cycle), ADVANCE (OVHD to ARB, ARB to XFER, XFER to MEMW), DROP (any occupied state to IDLE) and HOLD (all other cases).

A new writeback first looks for a pending copy of the same line. A slot in OVHD or ARB, or any queued overflow request, absorbs it, so nothing new is stored. Otherwise it takes the lowest-numbered empty slot. When every slot is busy, the request goes into a small FIFO overflow queue and the CPU is told to stall. Freeing an occupied slot ends its writeback. If the slot was in MEMW this is a normal completion; if it was in any earlier state the writeback is killed and counted. When the overflow queue holds anything at the moment of a free, its oldest request is replayed into the freed slot and the CPU gets a one-cycle unstall pulse. A separate lookup port lets a snoop find a pending writeback by address.

Top module: `wb_buffer`

## Requirements
- R1: After reset every slot is IDLE, and `used_count`, `ovf_level`, `kill_count`, `stall` and `unstall` are all zero. Each slot's state is packed into `slot_state` at bits [3*i+2:3*i] with IDLE=0, OVHD=1, ARB=2, XFER=3, MEMW=4.
- R2: An allocation that matches no pending line takes the lowest-index IDLE slot. From the next cycle that slot is in OVHD with the new address, and `used_count` is one higher.
- R3: An advance moves a slot one step, OVHD to ARB to XFER to MEMW. An advance aimed at an IDLE or MEMW slot leaves it unchanged.
- R4: The lookup port reports a slot hit, together with the slot index, only for a slot in OVHD or ARB whose address matches. Slots in XFER or MEMW never match. If several slots match, the lowest index wins.
- R5: The lookup also searches the overflow queue and raises `lookup_ovf_hit` when a queued request holds the same address.
- R6: An allocation whose address hits a slot in OVHD/ARB or a queued overflow request is collapsed into it. `used_count` and `ovf_level` do not change.
- R7: When no slot is IDLE, a non-matching allocation is appended to the overflow queue. `ovf_level` rises by one, and `stall` stays high while `ovf_level` is non-zero.
- R8: Freeing a slot in OVHD, ARB or XFER returns it to the pool and raises `kill_count` by one.
- R9: Freeing a slot in MEMW returns it to the pool without changing `kill_count`.
- R10: Freeing an IDLE slot has no effect. `used_count` never drops below zero and never exceeds the slot count.
- R11: A free of an occupied slot while the overflow queue is non-empty moves the oldest queued request into that slot in OVHD. `used_count` is unchanged, `ovf_level` falls by one, and `unstall` pulses high for exactly the next cycle. Queued requests replay in arrival order.
- R12: `stall` falls in the cycle after the last queued request is replayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | New writeback request this cycle |
| alloc_addr | input | AW | Line address of the new writeback |
| adv_valid | input | 1 | Advance one slot a stage |
| adv_idx | input | IW | Slot to advance |
| free_valid | input | 1 | Free (complete or kill) one slot |
| free_idx | input | IW | Slot to free |
| lookup_addr | input | AW | Snoop lookup address |
| lookup_hit | output | 1 | A slot in OVHD/ARB matches |
| lookup_idx | output | IW | Lowest matching slot |
| lookup_ovf_hit | output | 1 | A queued overflow request matches |
| slot_state | output | 3*NENT | Packed per-slot state codes |
| used_count | output | CW | Occupied slots |
| ovf_level | output | LW | Requests in the overflow queue |
| kill_count | output | KW | Killed writebacks, wrapping |
| stall | output | 1 | CPU must stall (overflow non-empty) |
| unstall | output | 1 | One-cycle pulse after each replay |

## Verification
The embedded properties assume that at most one of allocate, advance and free is requested in any cycle. They also assume the CPU never sends an allocation that would need a full overflow queue, so they treat such a request as illegal instead of dropping it quietly. The stimulus applies one operation per clock and never issues more overflowing allocations than the queue depth. The free and advance indices always name existing slots, and the lookup address changes only between edges, where the bench samples the combinational match outputs.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_OVHD = 3'd1,
        ST_ARB  = 3'd2,
        ST_XFER = 3'd3,
        ST_MEMW = 3'd4
    } wb_state_e;
endpackage

// File: rtl/wbb_slot.sv
module wbb_slot
    import wbb_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] load_addr_i,
    input  logic          adv_i,
    input  logic          drop_i,
    output wb_state_e     state_o,
    output logic [AW-1:0] addr_o
);
    wb_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i) state_d = ST_OVHD;
            ST_OVHD: begin
                if (load_i)      state_d = ST_OVHD;
                else if (drop_i) state_d = ST_IDLE;
                else if (adv_i)  state_d = ST_ARB;
            end
            ST_ARB: begin
                if (load_i)      state_d = ST_OVHD;
                else if (drop_i) state_d = ST_IDLE;
                else if (adv_i)  state_d = ST_XFER;
            end
            ST_XFER: begin
                if (load_i)      state_d = ST_OVHD;
                else if (drop_i) state_d = ST_IDLE;
                else if (adv_i)  state_d = ST_MEMW;
            end
            ST_MEMW: begin
                if (load_i)      state_d = ST_OVHD;
                else if (drop_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_o  <= '0;
        end else begin
            state_q <= state_d;
            if (load_i) addr_o <= load_addr_i;
        end
    end

    assign state_o = state_q;

    AST_MEMW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEMW && !load_i && !drop_i) |=> (state_q == ST_MEMW)); // R3
    AST_LOAD_ENTERS_OVHD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (state_q == ST_OVHD)); // R2
endmodule

// File: rtl/wbb_ovf.sv
module wbb_ovf #(
    parameter int AW    = 16,
    parameter int DEPTH = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic          pop_i,
    output logic [LW-1:0] level_o,
    output logic [AW-1:0] ord_addr_o [DEPTH],
    output logic          ord_vld_o  [DEPTH]
);
    logic [AW-1:0] mem_q [DEPTH];
    logic [PW-1:0] head_q;
    logic [LW-1:0] level_q;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] wrap(input int v);
        return (v >= DEPTH) ? PW'(v - DEPTH) : PW'(v);
    endfunction

    assign push_ok = push_i && (level_q < LW'(DEPTH));
    assign pop_ok  = pop_i && (level_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            level_q <= '0;
            for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
        end else begin
            if (push_ok) mem_q[wrap(int'(head_q) + int'(level_q))] <= push_addr_i;
            if (pop_ok)  head_q <= wrap(int'(head_q) + 1);
            level_q <= level_q + LW'(push_ok) - LW'(pop_ok);
        end
    end

    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_ord
            assign ord_addr_o[k] = mem_q[wrap(int'(head_q) + k)];
            assign ord_vld_o[k]  = (int'(level_q) > k);
        end
    endgenerate

    assign level_o = level_q;

    AST_OVF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LW'(DEPTH)); // R7
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (level_q != '0)); // R11
endmodule

// File: rtl/wbb_match.sv
module wbb_match
    import wbb_pkg::*;
#(
    parameter int NENT  = 4,
    parameter int AW    = 16,
    parameter int DEPTH = 2,
    localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1
) (
    input  logic [AW-1:0] key_i,
    input  wb_state_e     st_i     [NENT],
    input  logic [AW-1:0] addr_i   [NENT],
    input  logic [AW-1:0] q_addr_i [DEPTH],
    input  logic          q_vld_i  [DEPTH],
    output logic          slot_hit_o,
    output logic [IW-1:0] slot_idx_o,
    output logic          q_hit_o
);
    always_comb begin
        slot_hit_o = 1'b0;
        slot_idx_o = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if ((st_i[i] == ST_OVHD || st_i[i] == ST_ARB) && addr_i[i] == key_i) begin
                slot_hit_o = 1'b1;
                slot_idx_o = IW'(i);
            end
        end
    end

    always_comb begin
        q_hit_o = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (q_vld_i[k] && q_addr_i[k] == key_i) q_hit_o = 1'b1;
        end
    end
endmodule

// File: rtl/wb_buffer.sv
module wb_buffer
    import wbb_pkg::*;
#(
    parameter int NENT  = 4,
    parameter int AW    = 16,
    parameter int DEPTH = 2,
    parameter int KW    = 8,
    localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1,
    localparam int CW   = $clog2(NENT + 1),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc_valid,
    input  logic [AW-1:0]   alloc_addr,
    input  logic            adv_valid,
    input  logic [IW-1:0]   adv_idx,
    input  logic            free_valid,
    input  logic [IW-1:0]   free_idx,
    input  logic [AW-1:0]   lookup_addr,
    output logic            lookup_hit,
    output logic [IW-1:0]   lookup_idx,
    output logic            lookup_ovf_hit,
    output logic [3*NENT-1:0] slot_state,
    output logic [CW-1:0]   used_count,
    output logic [LW-1:0]   ovf_level,
    output logic [KW-1:0]   kill_count,
    output logic            stall,
    output logic            unstall
);
    wb_state_e     st      [NENT];
    logic [AW-1:0] ad      [NENT];
    logic [AW-1:0] q_addr  [DEPTH];
    logic          q_vld   [DEPTH];

    logic          a_hit, a_qhit;
    logic [IW-1:0] a_idx;
    logic          have_idle;
    logic [IW-1:0] idle_idx;
    logic          merged, take_slot, push, fr_live, replay, killed;
    wb_state_e     fr_state;

    // request matching for allocations and for snoop lookups
    wbb_match #(.NENT(NENT), .AW(AW), .DEPTH(DEPTH)) u_alloc_match (
        .key_i(alloc_addr), .st_i(st), .addr_i(ad), .q_addr_i(q_addr), .q_vld_i(q_vld),
        .slot_hit_o(a_hit), .slot_idx_o(a_idx), .q_hit_o(a_qhit)
    );
    wbb_match #(.NENT(NENT), .AW(AW), .DEPTH(DEPTH)) u_snoop_match (
        .key_i(lookup_addr), .st_i(st), .addr_i(ad), .q_addr_i(q_addr), .q_vld_i(q_vld),
        .slot_hit_o(lookup_hit), .slot_idx_o(lookup_idx), .q_hit_o(lookup_ovf_hit)
    );

    // lowest idle slot
    always_comb begin
        have_idle = 1'b0;
        idle_idx  = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (st[i] == ST_IDLE) begin
                have_idle = 1'b1;
                idle_idx  = IW'(i);
            end
        end
    end

    always_comb begin
        fr_state  = (int'(free_idx) < NENT) ? st[free_idx] : ST_IDLE;
        merged    = alloc_valid && (a_hit || a_qhit);
        take_slot = alloc_valid && !merged && have_idle;
        push      = alloc_valid && !merged && !have_idle;
        fr_live   = free_valid && (fr_state != ST_IDLE);
        replay    = fr_live && (ovf_level != '0);
        killed    = fr_live && (fr_state == ST_OVHD || fr_state == ST_ARB || fr_state == ST_XFER);
    end

    wbb_ovf #(.AW(AW), .DEPTH(DEPTH)) u_ovf (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .push_addr_i(alloc_addr), .pop_i(replay),
        .level_o(ovf_level), .ord_addr_o(q_addr), .ord_vld_o(q_vld)
    );

    generate
        for (genvar i = 0; i < NENT; i++) begin : g_slot
            logic load_i_w, adv_i_w, drop_i_w;
            assign load_i_w = (take_slot && idle_idx == IW'(i)) || (replay && free_idx == IW'(i));
            assign adv_i_w  = adv_valid && adv_idx == IW'(i);
            assign drop_i_w = fr_live && free_idx == IW'(i);
            wbb_slot #(.AW(AW)) u_slot (
                .clk(clk), .rst_n(rst_n),
                .load_i(load_i_w), .load_addr_i(replay ? q_addr[0] : alloc_addr),
                .adv_i(adv_i_w), .drop_i(drop_i_w),
                .state_o(st[i]), .addr_o(ad[i])
            );
            assign slot_state[3*i +: 3] = st[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_count <= '0;
            kill_count <= '0;
            unstall    <= 1'b0;
        end else begin
            used_count <= used_count + CW'(take_slot) - CW'(fr_live && !replay);
            kill_count <= kill_count + KW'(killed);
            unstall    <= replay;
        end
    end

    assign stall = (ovf_level != '0);

    AST_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alloc_valid, adv_valid, free_valid})); // R2
    AST_NO_LOST_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (ovf_level < LW'(DEPTH))); // R7
    AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        used_count <= CW'(NENT)); // R10
    AST_KILL_ONLY_ON_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !free_valid |=> $stable(kill_count)); // R8
    AST_MEMW_NO_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (free_valid && fr_state == ST_MEMW) |=> $stable(kill_count)); // R9
    AST_UNSTALL_AFTER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        !stall |=> !unstall); // R11
    AST_SNOOP_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_hit |-> (st[lookup_idx] == ST_OVHD || st[lookup_idx] == ST_ARB)); // R4
    AST_ALLOC_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        a_hit |-> (st[a_idx] == ST_OVHD || st[a_idx] == ST_ARB)); // R6
endmodule

// File: tb/tb_wb_buffer.sv
module tb_wb_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int NENT = 4, AW = 8, DEPTH = 2, KW = 8;
    localparam int IW = 2, CW = 3, LW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 1'b0, adv_valid = 1'b0, free_valid = 1'b0;
    logic [AW-1:0] alloc_addr = '0, lookup_addr = '0;
    logic [IW-1:0] adv_idx = '0, free_idx = '0;
    logic lookup_hit, lookup_ovf_hit, stall, unstall;
    logic [IW-1:0] lookup_idx;
    logic [3*NENT-1:0] slot_state;
    logic [CW-1:0] used_count;
    logic [LW-1:0] ovf_level;
    logic [KW-1:0] kill_count;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wb_buffer #(.NENT(NENT), .AW(AW), .DEPTH(DEPTH), .KW(KW)) dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_addr(alloc_addr),
        .adv_valid(adv_valid), .adv_idx(adv_idx), .free_valid(free_valid), .free_idx(free_idx),
        .lookup_addr(lookup_addr), .lookup_hit(lookup_hit), .lookup_idx(lookup_idx),
        .lookup_ovf_hit(lookup_ovf_hit), .slot_state(slot_state), .used_count(used_count),
        .ovf_level(ovf_level), .kill_count(kill_count), .stall(stall), .unstall(unstall)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int st_of(input int i);
        return int'((slot_state >> (3*i)) & 3'h7);
    endfunction

    task automatic op_alloc(input int a);
        @(negedge clk); alloc_valid = 1'b1; alloc_addr = AW'(a);
        @(posedge clk); #1; alloc_valid = 1'b0;
    endtask
    task automatic op_adv(input int i);
        @(negedge clk); adv_valid = 1'b1; adv_idx = IW'(i);
        @(posedge clk); #1; adv_valid = 1'b0;
    endtask
    task automatic op_free(input int i);
        @(negedge clk); free_valid = 1'b1; free_idx = IW'(i);
        @(posedge clk); #1; free_valid = 1'b0;
    endtask
    task automatic idle_cycle();
        @(posedge clk); #1;
    endtask
    task automatic look(input string req, input int a, input int hit, input int idx, input int qhit);
        lookup_addr = AW'(a); #1;
        chk({req, " hit"}, int'(lookup_hit), hit);
        if (hit != 0) chk({req, " idx"}, int'(lookup_idx), idx);
        chk({req, " ovf"}, int'(lookup_ovf_hit), qhit);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int k0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 slots", int'(slot_state), 0);
        chk("R1 used", int'(used_count), 0);
        chk("R1 level", int'(ovf_level), 0);
        chk("R1 kills", int'(kill_count), 0);
        chk("R1 stall", int'(stall), 0);
        chk("R1 unstall", int'(unstall), 0);

        // R2 fill lowest slots in order
        for (int i = 0; i < NENT; i++) begin
            op_alloc(8'h10 + i);
            chk("R2 state", st_of(i), 1);
            chk("R2 used", int'(used_count), i + 1);
        end
        // R3 advance slot i by i steps
        for (int i = 1; i < NENT; i++)
            for (int s = 0; s < i; s++) op_adv(i);
        op_adv(3);
        for (int i = 0; i < NENT; i++) chk("R3 stage", st_of(i), i + 1);

        // R4 lookup only OVHD/ARB
        for (int i = 0; i < NENT; i++) look("R4", 8'h10 + i, (i < 2) ? 1 : 0, i, 0);
        look("R4 miss", 8'h77, 0, 0, 0);

        // R6 collapse onto ARB slot
        op_alloc(8'h11);
        chk("R6 used", int'(used_count), 4);
        chk("R6 level", int'(ovf_level), 0);
        // R7 overflow
        op_alloc(8'h12);
        chk("R7 level", int'(ovf_level), 1);
        chk("R7 stall", int'(stall), 1);
        op_alloc(8'h20);
        chk("R7 level2", int'(ovf_level), 2);
        chk("R7 used", int'(used_count), 4);
        // R5 overflow search
        look("R5 q", 8'h20, 0, 0, 1);
        look("R5 xfer", 8'h12, 0, 0, 1);
        // R6 collapse onto overflow
        op_alloc(8'h20);
        chk("R6 qlevel", int'(ovf_level), 2);

        // R8 + R11 kill in OVHD with replay
        op_free(0);
        chk("R8 kill", int'(kill_count), 1);
        chk("R11 state", st_of(0), 1);
        chk("R11 used", int'(used_count), 4);
        chk("R11 level", int'(ovf_level), 1);
        chk("R11 unstall", int'(unstall), 1);
        chk("R7 stall held", int'(stall), 1);
        look("R11 replay", 8'h12, 1, 0, 0);
        idle_cycle();
        chk("R11 pulse", int'(unstall), 0);
        // R9 + R12 MEMW completion with replay
        op_free(3);
        chk("R9 kill", int'(kill_count), 1);
        chk("R11 state3", st_of(3), 1);
        chk("R12 level", int'(ovf_level), 0);
        chk("R12 stall", int'(stall), 0);
        chk("R11 unstall2", int'(unstall), 1);
        look("R11 replay2", 8'h20, 1, 3, 0);
        // R8 ARB kill
        op_free(1);
        chk("R8 kill arb", int'(kill_count), 2);
        chk("R8 used", int'(used_count), 3);
        chk("R8 idle", st_of(1), 0);
        chk("R11 no unstall", int'(unstall), 0);
        // R10 free of idle slot
        op_free(1);
        chk("R10 used", int'(used_count), 3);
        chk("R10 kill", int'(kill_count), 2);
        // R8 XFER kill
        op_free(2);
        chk("R8 kill xfer", int'(kill_count), 3);
        chk("R8 used2", int'(used_count), 2);
        op_free(0);
        op_free(3);
        chk("R8 kill5", int'(kill_count), 5);
        chk("R10 used0", int'(used_count), 0);
        op_free(0);
        chk("R10 floor", int'(used_count), 0);
        chk("R10 floor kill", int'(kill_count), 5);
        // R3 advance on idle slot
        op_adv(2);
        chk("R3 idle adv", int'(slot_state), 0);

        // sweep: free from each stage
        for (int s = 0; s < 4; s++) begin
            op_alloc(8'h40 + s);
            for (int a = 0; a < s; a++) op_adv(0);
            chk("R3 sweep stage", st_of(0), s + 1);
            k0 = int'(kill_count);
            op_free(0);
            chk((s < 3) ? "R8 sweep kill" : "R9 sweep nokill", int'(kill_count), k0 + ((s < 3) ? 1 : 0));
            chk("R10 sweep used", int'(used_count), 0);
        end

        // R11 replay order
        for (int i = 0; i < NENT; i++) op_alloc(8'h50 + i);
        op_alloc(8'h60);
        op_alloc(8'h61);
        chk("R7 level fill", int'(ovf_level), 2);
        op_free(2);
        look("R11 order1", 8'h60, 1, 2, 0);
        look("R11 order1q", 8'h61, 0, 0, 1);
        op_free(1);
        look("R11 order2", 8'h61, 1, 1, 0);
        chk("R12 stall end", int'(stall), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule